// File: doc/BRIEF.md
# Codec Variable-Rate Control Registers

This block is the small register bank that sits behind the control interface of an audio codec and governs its variable sample rates. It holds one extended status/control word and three sample-rate registers: front playback converter rate, stereo capture converter rate and microphone capture rate. An indexed register bus with an address, write data, write strobe, read strobe and registered read data gives access to all four.

Two enable bits in the control word gate write access to the rate registers. Clearing an enable bit has side effects. The matching rate registers go back to their default of BB80h (48000 Hz). A flush pulse lasting one clock cycle is sent to the affected conversion path. For the playback/capture pair, the slot request outputs are also held low. While the matching enable is clear, the rate-converter power-down outputs are asserted.

A separate bit in the control word powers down the microphone converter. A read-only flag in the same word shows the microphone converter's ready input.

Top module: `vrc_regbank`

## Requirements
- R1: While `rst_n` is low, and after it is released, the control word (index 2Ah) reads 4000h and all three rate registers read BB80h. Both flush outputs stay 0 during and after reset.
- R2: Control bit 14 is the microphone power-down. It is writable, resets to 1, and `mic_pd_o` equals its value.
- R3: Control bit 8 reads the value of `mic_ready_i` at the read strobe. Writing it has no effect.
- R4: While control bit 3 is 0, writes to the mic rate register (index 34h) are ignored and `mic_src_pd_o` is 1. While bit 3 is 1, `mic_src_pd_o` is 0.
- R5: A write that changes control bit 3 from 1 to 0 returns the mic rate register to BB80h in the same cycle. It also drives `mic_flush_o` high for exactly the following clock cycle.
- R6: While control bit 0 is 0, writes to the playback rate register (index 2Ch) and the capture rate register (index 32h) are ignored, and `dac_src_pd_o` and `adc_src_pd_o` are 1. While bit 0 is 1, both are 0.
- R7: A write that changes control bit 0 from 1 to 0 returns both the 2Ch and 32h rate registers to BB80h. It also drives `pcm_flush_o` high for exactly the following cycle.
- R8: While control bit 0 is 0, `slot_req_o` is all zeros. While bit 0 is 1, `slot_req_o` follows `slot_req_i` bit for bit.
- R9: All control bits other than 14, 8, 3 and 0 read as 0, and writes to them have no effect.
- R10: While the matching enable is set, a write to a rate register stores the full 16-bit value. A rate register read returns its current value whether or not the enable is set.
- R11: A flush pulse occurs only on a 1-to-0 change of its enable bit. Writing 1, or writing 0 to a bit that is already 0, gives no pulse.
- R12: Read data appears on `bus_rdata` in the cycle after the read strobe and holds until the next read. An index that is not mapped reads as 0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_addr | input | 7 | Register index |
| bus_wdata | input | 16 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 16 | Registered read data |
| mic_ready_i | input | 1 | Ready flag from the microphone converter |
| slot_req_i | input | NSLOT | Slot requests from the playback path |
| slot_req_o | output | NSLOT | Gated slot requests |
| mic_pd_o | output | 1 | Microphone converter power-down |
| mic_src_pd_o | output | 1 | Microphone rate-converter power-down |
| dac_src_pd_o | output | 1 | Playback rate-converter power-down |
| adc_src_pd_o | output | 1 | Capture rate-converter power-down |
| mic_flush_o | output | 1 | One-cycle flush of the microphone conversion path |
| pcm_flush_o | output | 1 | One-cycle flush of the playback/capture path |

## Verification
The hardest state to reach from the ports is a rate register that holds a non-default value at the moment its enable falls. The default is restored in the same cycle as the flush, so a bench that never wrote a rate could not tell a correct restore from a rate that was never changed. The stimulus therefore sets the enable first, writes distinctive rates and reads them back to confirm they were stored. It then clears the enable and checks the flush on the very next cycle, followed by the restored reads. The stimulus also writes 0 to an enable that is already 0, and asserts reset while both enables are set, to show that neither produces a pulse.

// File: rtl/vrc_pkg.sv
package vrc_pkg;

  localparam int IDX_W = 7;
  localparam int REG_W = 16;

  localparam logic [IDX_W-1:0] IDX_EXT = 7'h2A;
  localparam logic [IDX_W-1:0] IDX_DAC = 7'h2C;
  localparam logic [IDX_W-1:0] IDX_ADC = 7'h32;
  localparam logic [IDX_W-1:0] IDX_MIC = 7'h34;

  localparam int BIT_MICPD  = 14;
  localparam int BIT_MICRDY = 8;
  localparam int BIT_MICVAR = 3;
  localparam int BIT_PCMVAR = 0;

  localparam int NRATE  = 3;
  localparam int RI_DAC = 0;
  localparam int RI_ADC = 1;
  localparam int RI_MIC = 2;

  typedef struct packed {
    logic mic_pd;
    logic mic_var;
    logic pcm_var;
  } ctl_t;

  localparam ctl_t CTL_RESET = '{mic_pd: 1'b1, mic_var: 1'b0, pcm_var: 1'b0};

  function automatic logic [IDX_W-1:0] rate_index(input int k);
    logic [IDX_W-1:0] r;
    case (k)
      RI_DAC:  r = IDX_DAC;
      RI_ADC:  r = IDX_ADC;
      default: r = IDX_MIC;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/vrc_ctrl_reg.sv
module vrc_ctrl_reg
  import vrc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic [REG_W-1:0] wdata,
  output ctl_t             ctl_q,
  output logic             mic_clr,
  output logic             pcm_clr,
  output logic             mic_flush_o,
  output logic             pcm_flush_o
);

  ctl_t ctl_d;
  logic mic_flush_d;
  logic pcm_flush_d;

  always_comb begin
    ctl_d = ctl_q;
    if (wr_hit) begin
      ctl_d.mic_pd  = wdata[BIT_MICPD];
      ctl_d.mic_var = wdata[BIT_MICVAR];
      ctl_d.pcm_var = wdata[BIT_PCMVAR];
    end
    mic_clr     = ctl_q.mic_var & ~ctl_d.mic_var;
    pcm_clr     = ctl_q.pcm_var & ~ctl_d.pcm_var;
    mic_flush_d = mic_clr;
    pcm_flush_d = pcm_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q       <= CTL_RESET;
      mic_flush_o <= 1'b0;
      pcm_flush_o <= 1'b0;
    end else begin
      ctl_q       <= ctl_d;
      mic_flush_o <= mic_flush_d;
      pcm_flush_o <= pcm_flush_d;
    end
  end

  AST_MIC_FALL_FLUSHES: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl_q.mic_var) |-> mic_flush_o); // R5
  AST_MIC_FLUSH_ONLY_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    mic_flush_o |-> $fell(ctl_q.mic_var)); // R11
  AST_PCM_FALL_FLUSHES: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl_q.pcm_var) |-> pcm_flush_o); // R7
  AST_PCM_FLUSH_ONLY_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    pcm_flush_o |-> $fell(ctl_q.pcm_var)); // R11
  AST_MIC_FLUSH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mic_flush_o |=> !mic_flush_o); // R5
  AST_PCM_FLUSH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pcm_flush_o |=> !pcm_flush_o); // R7

endmodule

// File: rtl/vrc_rate_reg.sv
module vrc_rate_reg
  import vrc_pkg::*;
#(
  parameter logic [IDX_W-1:0] INDEX   = IDX_DAC,
  parameter logic [REG_W-1:0] DEFAULT = 16'hBB80
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [IDX_W-1:0] addr,
  input  logic [REG_W-1:0] wdata,
  input  logic             en,
  input  logic             clr,
  output logic [REG_W-1:0] rate_q
);

  logic             wr_ok;
  logic [REG_W-1:0] rate_d;

  always_comb begin
    wr_ok  = wr && (addr == INDEX) && en;
    rate_d = rate_q;
    if (clr) begin
      rate_d = DEFAULT;
    end else if (wr_ok) begin
      rate_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= DEFAULT;
    end else begin
      rate_q <= rate_d;
    end
  end

  AST_RATE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(rate_q)); // R4 R6
  AST_RATE_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (rate_q == DEFAULT)); // R5 R7

endmodule

// File: rtl/vrc_slot_gate.sv
module vrc_slot_gate #(
  parameter int NSLOT = 4
) (
  input  logic             en,
  input  logic [NSLOT-1:0] req_i,
  output logic [NSLOT-1:0] req_o
);

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    assign req_o[s] = en & req_i[s];
  end

endmodule

// File: rtl/vrc_rdmux.sv
module vrc_rdmux
  import vrc_pkg::*;
(
  input  logic [IDX_W-1:0]            addr,
  input  ctl_t                        ctl,
  input  logic                        mic_ready,
  input  logic [NRATE-1:0][REG_W-1:0] rates,
  output logic [REG_W-1:0]            rdata
);

  logic [REG_W-1:0] ext_word;

  always_comb begin
    ext_word             = '0;
    ext_word[BIT_MICPD]  = ctl.mic_pd;
    ext_word[BIT_MICRDY] = mic_ready;
    ext_word[BIT_MICVAR] = ctl.mic_var;
    ext_word[BIT_PCMVAR] = ctl.pcm_var;
    case (addr)
      IDX_EXT: rdata = ext_word;
      IDX_DAC: rdata = rates[RI_DAC];
      IDX_ADC: rdata = rates[RI_ADC];
      IDX_MIC: rdata = rates[RI_MIC];
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/vrc_regbank.sv
module vrc_regbank
  import vrc_pkg::*;
#(
  parameter int               NSLOT        = 4,
  parameter logic [REG_W-1:0] RATE_DEFAULT = 16'hBB80
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [6:0]       bus_addr,
  input  logic [15:0]      bus_wdata,
  input  logic             bus_wr,
  input  logic             bus_rd,
  output logic [15:0]      bus_rdata,
  input  logic             mic_ready_i,
  input  logic [NSLOT-1:0] slot_req_i,
  output logic [NSLOT-1:0] slot_req_o,
  output logic             mic_pd_o,
  output logic             mic_src_pd_o,
  output logic             dac_src_pd_o,
  output logic             adc_src_pd_o,
  output logic             mic_flush_o,
  output logic             pcm_flush_o
);

  localparam logic [REG_W-1:0] RSVD_MASK =
    REG_W'((1 << BIT_MICPD) | (1 << BIT_MICRDY) | (1 << BIT_MICVAR) | (1 << BIT_PCMVAR));

  ctl_t                        ctl_q;
  logic                        mic_clr;
  logic                        pcm_clr;
  logic                        ext_wr;
  logic [NRATE-1:0][REG_W-1:0] rate_q;
  logic [REG_W-1:0]            rd_mux;
  logic [REG_W-1:0]            rdata_d;
  logic [REG_W-1:0]            rdata_q;

  assign ext_wr = bus_wr && (bus_addr == IDX_EXT);

  vrc_ctrl_reg i_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_hit      (ext_wr),
    .wdata       (bus_wdata),
    .ctl_q       (ctl_q),
    .mic_clr     (mic_clr),
    .pcm_clr     (pcm_clr),
    .mic_flush_o (mic_flush_o),
    .pcm_flush_o (pcm_flush_o)
  );

  for (genvar k = 0; k < NRATE; k++) begin : g_rate
    localparam logic [IDX_W-1:0] K_IDX = rate_index(k);
    localparam bit               K_MIC = (k == RI_MIC);
    logic k_en;
    logic k_clr;
    assign k_en  = K_MIC ? ctl_q.mic_var : ctl_q.pcm_var;
    assign k_clr = K_MIC ? mic_clr : pcm_clr;
    vrc_rate_reg #(
      .INDEX   (K_IDX),
      .DEFAULT (RATE_DEFAULT)
    ) i_rate (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (bus_wr),
      .addr   (bus_addr),
      .wdata  (bus_wdata),
      .en     (k_en),
      .clr    (k_clr),
      .rate_q (rate_q[k])
    );
  end

  vrc_slot_gate #(.NSLOT(NSLOT)) i_slot (
    .en    (ctl_q.pcm_var),
    .req_i (slot_req_i),
    .req_o (slot_req_o)
  );

  vrc_rdmux i_rdmux (
    .addr      (bus_addr),
    .ctl       (ctl_q),
    .mic_ready (mic_ready_i),
    .rates     (rate_q),
    .rdata     (rd_mux)
  );

  always_comb begin
    rdata_d = rdata_q;
    if (bus_rd) begin
      rdata_d = rd_mux;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata    = rdata_q;
  assign mic_pd_o     = ctl_q.mic_pd;
  assign mic_src_pd_o = ~ctl_q.mic_var;
  assign dac_src_pd_o = ~ctl_q.pcm_var;
  assign adc_src_pd_o = ~ctl_q.pcm_var;

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bus_rd) && $past(bus_addr) == IDX_EXT) |-> ((bus_rdata & ~RSVD_MASK) == '0)); // R9
  AST_SLOT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    dac_src_pd_o |-> (slot_req_o == '0)); // R8
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_rd) |-> $stable(bus_rdata)); // R12
  AST_NO_FLUSH_WHEN_IDLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_wr && mic_src_pd_o) |=> !mic_flush_o); // R11

endmodule

// File: tb/test_vrc_regbank.sv
module test_vrc_regbank;

  localparam int NSLOT = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [6:0]       bus_addr = '0;
  logic [15:0]      bus_wdata = '0;
  logic             bus_wr = 1'b0;
  logic             bus_rd = 1'b0;
  logic [15:0]      bus_rdata;
  logic             mic_ready_i = 1'b0;
  logic [NSLOT-1:0] slot_req_i = '0;
  logic [NSLOT-1:0] slot_req_o;
  logic             mic_pd_o, mic_src_pd_o, dac_src_pd_o, adc_src_pd_o;
  logic             mic_flush_o, pcm_flush_o;

  int n_vec = 0;
  int n_bad = 0;
  bit reported = 0;

  always #4 clk = ~clk;

  vrc_regbank #(.NSLOT(NSLOT)) i_vrc_regbank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .mic_ready_i(mic_ready_i), .slot_req_i(slot_req_i), .slot_req_o(slot_req_o),
    .mic_pd_o(mic_pd_o), .mic_src_pd_o(mic_src_pd_o), .dac_src_pd_o(dac_src_pd_o),
    .adc_src_pd_o(adc_src_pd_o), .mic_flush_o(mic_flush_o), .pcm_flush_o(pcm_flush_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    end
    $finish;
  endtask

  // Write: strobe is high for one posedge; returns at the following negedge.
  task automatic wr(input logic [6:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // Read: data is registered at the strobe edge and sampled at the next negedge.
  task automatic rd(input logic [6:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic expect_rd(input string req, input logic [6:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    check(req, {16'h0, v}, {16'h0, exp});
  endtask

  task automatic t_reset();
    slot_req_i = 4'hF;
    check("R1 flush in reset", {30'h0, mic_flush_o, pcm_flush_o}, 0);
    expect_rd("R1 ext", 7'h2A, 16'h4000);
    expect_rd("R1 dac", 7'h2C, 16'hBB80);
    expect_rd("R1 adc", 7'h32, 16'hBB80);
    expect_rd("R1 mic", 7'h34, 16'hBB80);
    check("R2 pd reset", {31'h0, mic_pd_o}, 1);
    check("R4 mic src pd", {31'h0, mic_src_pd_o}, 1);
    check("R6 pcm src pd", {30'h0, dac_src_pd_o, adc_src_pd_o}, 32'h3);
    check("R8 slots gated", {28'h0, slot_req_o}, 0);
  endtask

  task automatic t_powerdown();
    wr(7'h2A, 16'h0000);
    check("R2 pd cleared", {31'h0, mic_pd_o}, 0);
    expect_rd("R2 ext", 7'h2A, 16'h0000);
    wr(7'h2A, 16'h4000);
    check("R2 pd set", {31'h0, mic_pd_o}, 1);
  endtask

  task automatic t_ready();
    mic_ready_i = 1'b1;
    expect_rd("R3 ready shown", 7'h2A, 16'h4100);
    mic_ready_i = 1'b0;
    wr(7'h2A, 16'h0100);
    expect_rd("R3 write ignored", 7'h2A, 16'h0000);
  endtask

  task automatic t_locked();
    wr(7'h2C, 16'h1234);
    wr(7'h32, 16'h2345);
    wr(7'h34, 16'h3456);
    expect_rd("R6 dac locked", 7'h2C, 16'hBB80);
    expect_rd("R6 adc locked", 7'h32, 16'hBB80);
    expect_rd("R4 mic locked", 7'h34, 16'hBB80);
  endtask

  task automatic t_mic_rate();
    wr(7'h2A, 16'h0008);
    check("R11 no flush on set", {30'h0, mic_flush_o, pcm_flush_o}, 0);
    check("R4 mic src on", {31'h0, mic_src_pd_o}, 0);
    check("R6 pcm src still off", {31'h0, dac_src_pd_o}, 1);
    wr(7'h34, 16'hAC44);
    expect_rd("R10 mic stored", 7'h34, 16'hAC44);
    wr(7'h2C, 16'h1111);
    expect_rd("R6 dac still locked", 7'h2C, 16'hBB80);
    wr(7'h2A, 16'h0000);
    check("R5 mic flush", {30'h0, mic_flush_o, pcm_flush_o}, 32'h2);
    @(negedge clk);
    check("R5 mic flush one cycle", {31'h0, mic_flush_o}, 0);
    expect_rd("R5 mic restored", 7'h34, 16'hBB80);
    check("R4 mic src off", {31'h0, mic_src_pd_o}, 1);
    wr(7'h2A, 16'h0000);
    check("R11 zero on zero", {30'h0, mic_flush_o, pcm_flush_o}, 0);
  endtask

  task automatic t_pcm_rate();
    wr(7'h2A, 16'h0001);
    check("R6 pcm src on", {30'h0, dac_src_pd_o, adc_src_pd_o}, 0);
    slot_req_i = 4'h5;
    #1 check("R8 slots follow", {28'h0, slot_req_o}, 32'h5);
    slot_req_i = 4'hA;
    #1 check("R8 slots follow b", {28'h0, slot_req_o}, 32'hA);
    wr(7'h2C, 16'h5622);
    wr(7'h32, 16'h7D00);
    wr(7'h34, 16'h1F40);
    expect_rd("R10 dac stored", 7'h2C, 16'h5622);
    expect_rd("R10 adc stored", 7'h32, 16'h7D00);
    expect_rd("R4 mic locked pcm on", 7'h34, 16'hBB80);
    wr(7'h2A, 16'h0000);
    check("R7 pcm flush", {30'h0, mic_flush_o, pcm_flush_o}, 32'h1);
    check("R8 slots gated again", {28'h0, slot_req_o}, 0);
    @(negedge clk);
    check("R7 pcm flush one cycle", {31'h0, pcm_flush_o}, 0);
    expect_rd("R7 dac restored", 7'h2C, 16'hBB80);
    expect_rd("R7 adc restored", 7'h32, 16'hBB80);
  endtask

  task automatic t_reserved();
    wr(7'h2A, 16'hFFFF);
    check("R11 no flush on FFFF", {30'h0, mic_flush_o, pcm_flush_o}, 0);
    expect_rd("R9 reserved zero", 7'h2A, 16'h4009);
    wr(7'h2A, 16'h0000);
    check("R5 R7 both flush", {30'h0, mic_flush_o, pcm_flush_o}, 32'h3);
  endtask

  task automatic t_bus();
    logic [15:0] v;
    expect_rd("R12 unmapped", 7'h10, 16'h0000);
    expect_rd("R12 unmapped odd", 7'h2B, 16'h0000);
    rd(7'h2C, v);
    @(negedge clk);
    @(negedge clk);
    check("R12 rdata holds", {16'h0, bus_rdata}, {16'h0, 16'hBB80});
  endtask

  task automatic t_reset_midrun();
    wr(7'h2A, 16'h0009);
    wr(7'h34, 16'h2EE0);
    wr(7'h2C, 16'h3E80);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 no flush at reset", {30'h0, mic_flush_o, pcm_flush_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 no flush after reset", {30'h0, mic_flush_o, pcm_flush_o}, 0);
    expect_rd("R1 ext after reset", 7'h2A, 16'h4000);
    expect_rd("R1 mic after reset", 7'h34, 16'hBB80);
    expect_rd("R1 dac after reset", 7'h2C, 16'hBB80);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_powerdown();
    t_ready();
    t_locked();
    t_mic_rate();
    t_pcm_rate();
    t_reserved();
    t_bus();
    t_reset_midrun();
    report();
  end

endmodule